// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a burst request into the column addresses the memory array visits, one per clock. A request is a start strobe together with a starting column, a 3-bit length code and a burst-type bit. The block then presents the column addresses of the burst in order. Each address comes with a valid flag, and the final address of a finite burst also carries a last flag.

A burst may be sequential or interleaved. A finite burst touches only the low address bits that lie inside its length-aligned block: it counts upward and wraps in sequential mode, or it XORs the start with a beat index in interleaved mode. A full-row burst walks the whole row and wraps around it until it is stopped. A stop request, or a fresh start, cuts the burst short. A new start is accepted on any cycle. A request whose length code is undefined, or that asks for an interleaved full-row burst, is refused and flagged. The column width is a parameter, for a 9-bit or a 10-bit page.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last and cfg_err are all low.
- R2: When an accepted start is sampled on a clock edge, col_valid is high and col equals start_col in the following cycle. A start sampled while a burst is running abandons that burst at once.
- R3: Length codes 000, 001, 010, 011 and 111 select bursts of 1, 2, 4, 8 and full-row beats. A finite burst gives exactly that many valid beats, and col_last is high only on the final one.
- R4: When ilv is 0, the low log2(L) bits of beat k equal (start low bits + k) mod L. For example, start 2 with length 4 gives 2,3,0,1.
- R5: When ilv is 1, the low log2(L) bits of beat k equal start low bits XOR k. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R6: Column bits at or above log2(L) keep the start value for the whole of a finite burst.
- R7: A full-row burst (code 111, ilv 0) gives (start + k) mod 2^COL_W on beat k. It never raises col_last and runs until it is stopped or restarted.
- R8: A term sampled without start makes col_valid low in the next cycle. When start and term are sampled together, start wins.
- R9: A start with code 100, 101 or 110, or with code 111 and ilv 1, is refused. cfg_err is high for exactly the next cycle, col_valid is low, and any running burst is abandoned.
- R10: In the cycle after a beat with col_last high, col_valid is low unless a new start was sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the values below |
| start_col | input | COL_W | Starting column |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | 0 sequential, 1 interleaved |
| term | input | 1 | Stop the running burst |
| col | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | col holds a beat |
| col_last | output | 1 | Final beat of a finite burst |
| cfg_err | output | 1 | One-cycle flag for a refused request |

## Verification
Two situations are hardest to reach from the ports. The first is the wrap of a full-row burst past the top column. The bench starts such a burst four columns below the top of the row and lets it run past the end. The second is the interaction of a new request with a burst that is still running. The bench issues good starts, refused starts and start-with-term in the middle of bursts. A behavioural model predicts every beat, and the captured interleaved sequence is also compared with the literal order.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  typedef enum logic [2:0] {
    BL_1   = 3'b000,
    BL_2   = 3'b001,
    BL_4   = 3'b010,
    BL_8   = 3'b011,
    BL_ROW = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       code,
  input  logic             ilv,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             ok
);
  logic known;

  always_comb begin
    mask  = '0;
    full  = 1'b0;
    known = 1'b1;
    case (code)
      BL_1:    mask = '0;
      BL_2:    mask = COL_W'(1);
      BL_4:    mask = COL_W'(3);
      BL_8:    mask = COL_W'(7);
      BL_ROW: begin
        mask = '1;
        full = 1'b1;
      end
      default: known = 1'b0;
    endcase
    ok = known && !(full && ilv);
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mix;

  assign sum = base + idx;
  assign mix = ilv ? (base ^ idx) : sum;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr[i] = mask[i] ? mix[i] : base[i];
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             term,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last,
  output logic             cfg_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ok;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] cnt_n;
  logic [COL_W-1:0] addr_n;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code (len_code),
    .ilv  (ilv),
    .mask (dec_mask),
    .full (dec_full),
    .ok   (dec_ok)
  );

  assign cnt_n = cnt_q + COL_W'(1);

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base (base_q),
    .idx  (cnt_n),
    .mask (mask_q),
    .ilv  (ilv_q),
    .addr (addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      cfg_err   <= 1'b0;
      col       <= '0;
      base_q    <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      cfg_err <= 1'b0;
      if (start) begin
        if (dec_ok) begin
          col_valid <= 1'b1;
          col       <= start_col;
          col_last  <= !dec_full && (dec_mask == '0);
          base_q    <= start_col;
          mask_q    <= dec_mask;
          full_q    <= dec_full;
          ilv_q     <= ilv;
          cnt_q     <= '0;
        end else begin
          col_valid <= 1'b0;
          col_last  <= 1'b0;
          cfg_err   <= 1'b1;
        end
      end else if (term) begin
        col_valid <= 1'b0;
        col_last  <= 1'b0;
      end else if (col_valid) begin
        if (col_last) begin
          col_valid <= 1'b0;
          col_last  <= 1'b0;
        end else begin
          cnt_q    <= cnt_n;
          col      <= addr_n;
          col_last <= !full_q && (cnt_n == mask_q);
        end
      end
    end
  end
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_code,
  input logic             ilv,
  input logic             term,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             col_last,
  input logic             cfg_err
);
  logic             good;
  logic [COL_W-1:0] want_mask;
  logic [COL_W-1:0] hold_col;
  logic [COL_W-1:0] hold_mask;

  always_comb begin
    good = 1'b1;
    case (len_code)
      3'd0: want_mask = '0;
      3'd1: want_mask = COL_W'(1);
      3'd2: want_mask = COL_W'(3);
      3'd3: want_mask = COL_W'(7);
      3'd7: begin want_mask = '1; good = !ilv; end
      default: begin want_mask = '1; good = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_col  <= '0;
      hold_mask <= '1;
    end else if (start && good) begin
      hold_col  <= start_col;
      hold_mask <= want_mask;
    end
  end

  p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
    (start && good) |=> (col_valid && col == $past(start_col)));

  p_last_in_beat_r3: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  p_high_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> ((col & ~hold_mask) == (hold_col & ~hold_mask)));

  p_term_stops_r8: assert property (@(posedge clk) disable iff (rst)
    (term && !start) |=> !col_valid);

  p_refused_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !good) |=> (cfg_err && !col_valid));

  p_end_after_last_r10: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_last && !start) |=> !col_valid);
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_col (start_col),
  .len_code  (len_code),
  .ilv       (ilv),
  .term      (term),
  .col       (col),
  .col_valid (col_valid),
  .col_last  (col_last),
  .cfg_err   (cfg_err)
);

// File: tb/burst_colgen_tb.sv
`timescale 1ns/1ps
module burst_colgen_tb;
  localparam int COL_W = 10;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             ilv = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col;
  logic             col_valid;
  logic             col_last;
  logic             cfg_err;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .term(term),
    .col(col), .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
  );

  // behavioural reference
  bit m_act, m_err, m_full, m_ilv;
  int m_base, m_len, m_idx;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return ROW;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_col();
    int lo, blk;
    if (m_full) return (m_base + m_idx) % ROW;
    lo  = m_base % m_len;
    blk = m_base - lo;
    if (m_ilv) return blk + (lo ^ m_idx);
    return blk + ((lo + m_idx) % m_len);
  endfunction

  function automatic bit exp_last();
    return m_act && !m_full && (m_idx == m_len - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_err = 0;
    end else begin
      m_err = 0;
      if (start) begin
        if (len_of(len_code) != 0 && !(len_code == 3'd7 && ilv)) begin
          m_act = 1; m_base = start_col; m_len = len_of(len_code);
          m_full = (len_code == 3'd7); m_ilv = ilv; m_idx = 0;
        end else begin
          m_act = 0; m_err = 1;
        end
      end else if (term) m_act = 0;
      else if (m_act) begin
        if (exp_last()) m_act = 0;
        else m_idx = m_idx + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int seen[$];
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "valid", col_valid, m_act);
      check(cur_req, "last", col_last, exp_last());
      check(cur_req, "cfg_err", cfg_err, m_err);
      if (m_act) begin
        check(cur_req, "col", col, exp_col());
        seen.push_back(col);
      end
    end
  end

  task automatic go(input int c, input int code, input bit il, input int idle);
    @(negedge clk);
    start = 1; start_col = COL_W'(c); len_code = 3'(code); ilv = il;
    @(negedge clk);
    start = 0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog run did not end actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "valid after reset", col_valid, 0);
    check("R1", "last after reset", col_last, 0);
    check("R1", "err after reset", cfg_err, 0);

    cur_req = "R3"; go(9, 0, 0, 3); go(10, 1, 0, 3); go(16, 3, 0, 10);
    cur_req = "R4"; go(2, 2, 0, 5); go(13, 3, 0, 9);
    cur_req = "R5";
    @(negedge clk); seen.delete();
    go(5, 3, 1, 8);
    begin
      int ref5[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
      check("R5", "beat count", seen.size(), 8);
      foreach (ref5[i]) if (i < seen.size()) check("R5", "order", seen[i], ref5[i]);
    end
    go(6, 2, 1, 5); go(3, 1, 1, 3);
    cur_req = "R6"; go(12'h3A6, 3, 0, 9); go(12'h2F5, 3, 1, 9); go(12'h1FE, 2, 0, 5);
    cur_req = "R7"; go(1020, 7, 0, 12);
    cur_req = "R8";
    @(negedge clk); term = 1; @(negedge clk); term = 0; repeat (2) @(negedge clk);
    go(40, 3, 0, 2);
    term = 1; @(negedge clk); term = 0; repeat (2) @(negedge clk);
    @(negedge clk); start = 1; term = 1; start_col = 10'd70; len_code = 3'd2; ilv = 0;
    @(negedge clk); start = 0; term = 0; repeat (5) @(negedge clk);
    cur_req = "R2"; go(100, 3, 0, 2); go(200, 3, 1, 1); go(300, 2, 0, 0); go(7, 0, 0, 3);
    cur_req = "R9";
    go(50, 4, 0, 2); go(51, 5, 1, 2); go(52, 6, 0, 2); go(53, 7, 1, 2);
    go(60, 3, 0, 2); go(61, 5, 0, 3);
    cur_req = "R10"; go(80, 1, 0, 0); go(90, 0, 0, 0); go(95, 0, 1, 4);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule